// File: doc/BRIEF.md
# Latched Level Interrupt Controller

This block gathers 32 level-sensitive request lines from peripherals into one interrupt wire for a small soft CPU. Every clock the request lines are sampled; any sampled-high line sets its bit in a sticky pending register. The pending bits are gated by a software-controlled enable mask, and the registered output is high whenever at least one enabled bit is pending.

The CPU sees two registers through a plain synchronous strobe port. Address 0 is the enable mask, which is replaced whole on a write. Address 1 holds the pending bits, and a write to it clears each bit written as one. In the same update the sampled request levels are OR-ed back in, so a line that is still asserted cannot be acknowledged away. Each line also has an event counter that advances once for each rising edge of its sampled level. Any counter can be read through an indexed statistics port.

Top module: `irq_latch_ctrl`

## Requirements
- R1: Each clock edge, `req_lines` is sampled into a live-state vector in which bit n belongs to line n. The sampled value takes part in the pending update at the following edge.
- R2: At every edge, pending becomes (old pending with acknowledged bits cleared) OR live state. A pending bit never clears because its line has gone low.
- R3: `cpu_irq` is a register. After each edge it equals the OR-reduction of (pending AND mask), using the pending and mask values loaded at that same edge.
- R4: A write with `reg_addr`=1 clears every pending bit whose `reg_wdata` bit is 1 and leaves bits written as 0 alone. A line whose live state is still high stays pending (clear first, then set).
- R5: A write with `reg_addr`=0 replaces all 32 mask bits with `reg_wdata`, and `cpu_irq` reflects the new mask at that same edge.
- R6: On an edge with `reg_rd` high, `reg_rdata` loads the value held before that edge: the mask when `reg_addr`=0, the pending bits when `reg_addr`=1. Without `reg_rd`, `reg_rdata` holds its value.
- R7: The counter of line n increments by one at the edge after its live-state bit goes from 0 to 1. A line held high for many cycles counts only once.
- R8: `stat_count` shows, without delay, the counter of the line selected by `stat_idx`.
- R9: A clock edge with `rst_n` low clears the mask, the pending bits, the live state, all counters, `reg_rdata` and `cpu_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_lines | input | 32 | Level-sensitive request lines, bit n = line n |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 selects the mask, 1 selects the pending bits |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| stat_idx | input | 5 | Line whose event counter is shown |
| stat_count | output | 32 | Event counter of the selected line |
| cpu_irq | output | 1 | Combined interrupt request to the CPU |

## Verification
Two functions can meet on one edge. An acknowledge write can land on a pending bit whose line is still high, and a mask write can land on an edge where pending is also changing. The bench holds a line high while it writes ones to that line's pending bit, then checks that the bit and `cpu_irq` survive. It releases the line and acknowledges again to see the bit clear. Random traffic mixes writes, reads and toggling request lines on the same cycles, and every cycle is compared against a cycle model built from the requirements.

// File: rtl/irq_latch_pkg.sv
// Package: shared constants and types of the latched interrupt controller.
// Assumes a one-bit register address space holding two registers.
package irq_latch_pkg;

    // Register selector decoded from the one-bit address.
    typedef enum logic {
        SEL_MASK = 1'b0,
        SEL_PEND = 1'b1
    } reg_sel_e;

    // Default geometry of the controller.
    localparam int unsigned DEF_LINES = 32;
    localparam int unsigned DEF_CNT_W = 32;

endpackage

// File: rtl/irq_line_sampler.sv
// Module: irq_line_sampler
// Samples the raw request lines once per clock and remembers the previous
// sample so rising edges of the sampled level can be detected.
// Assumes the request lines are already synchronous to clk.
module irq_line_sampler #(
    parameter int unsigned LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_lines,
    output logic [LINES-1:0] live_q,
    output logic [LINES-1:0] rise
);

    logic [LINES-1:0] prev_q;

    // Capture the current and previous sampled line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            prev_q <= '0;
        end else begin
            live_q <= raw_lines;
            prev_q <= live_q;
        end
    end

    // Flag lines whose sampled level just went from low to high.
    always_comb begin
        rise = live_q & ~prev_q;
    end

    // R1: the live state follows the raw lines one edge later.
    p_live_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (live_q == $past(raw_lines)));

endmodule

// File: rtl/irq_pending_core.sv
// Module: irq_pending_core
// Holds the enable mask and sticky pending register, handles the
// write-one-to-clear acknowledge, and produces the registered CPU request
// and registered read data.
// Assumes a single-cycle write and read strobe with no wait states.
module irq_pending_core
    import irq_latch_pkg::*;
#(
    parameter int unsigned LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] live,
    input  logic             wr_en,
    input  logic             rd_en,
    input  reg_sel_e         sel,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] rdata,
    output logic             irq_out
);

    logic [LINES-1:0] mask_q;
    logic [LINES-1:0] pend_q;
    logic [LINES-1:0] ack_vec;
    logic [LINES-1:0] mask_nxt;
    logic [LINES-1:0] pend_nxt;

    // Decode the acknowledge vector and the next mask from the write strobe.
    always_comb begin
        ack_vec  = (wr_en && sel == SEL_PEND) ? wdata : '0;
        mask_nxt = (wr_en && sel == SEL_MASK) ? wdata : mask_q;
    end

    // Clear acknowledged bits first, then merge in live levels.
    always_comb begin
        pend_nxt = (pend_q & ~ack_vec) | live;
    end

    // Update mask, pending and the CPU request together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            pend_q  <= '0;
            irq_out <= 1'b0;
        end else begin
            mask_q  <= mask_nxt;
            pend_q  <= pend_nxt;
            irq_out <= |(pend_nxt & mask_nxt);
        end
    end

    // Return the selected register value on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= (sel == SEL_PEND) ? pend_q : mask_q;
        end
    end

    // R2: pending bits not acknowledged are never lost.
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(pend_q & ~ack_vec)) == $past(pend_q & ~ack_vec)));

    // R4: a live line is pending after the edge, even if acknowledged.
    p_live_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(live)) == $past(live)));

    // R3: the request output agrees with the stored mask and pending bits.
    p_irq_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == |(pend_q & mask_q));

    // R5: a mask write is taken whole.
    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_MASK) |=> (mask_q == $past(wdata)));

    // R9: reset leaves the controller quiet.
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0 && pend_q == '0 && !irq_out));

endmodule

// File: rtl/irq_event_counters.sv
// Module: irq_event_counters
// One wrapping event counter per line, advanced by a single-cycle rise
// pulse, plus an index-selected view of the counters.
// Assumes LINES is at most 2**IDX_W.
module irq_event_counters #(
    parameter int unsigned LINES = 32,
    parameter int unsigned CNT_W = 32,
    parameter int unsigned IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] rise,
    input  logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] count_out
);

    logic [CNT_W-1:0] cnt_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Advance this line's counter on a rise pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (rise[g]) begin
                cnt_q[g] <= cnt_q[g] + 1'b1;
            end
        end

        // R7: a rise adds exactly one.
        p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> (cnt_q[g] == $past(cnt_q[g]) + 1'b1));

        // R7: without a rise the counter holds.
        p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !rise[g] |=> $stable(cnt_q[g]));
    end

    // Show the counter picked by the index.
    always_comb begin
        count_out = cnt_q[idx];
    end

endmodule

// File: rtl/irq_latch_ctrl.sv
// Module: irq_latch_ctrl (top)
// Level-latched interrupt controller: samples request lines, latches them
// into sticky pending bits, gates them with a mask into one CPU request,
// and counts rising edges per line.
// Assumes synchronous request lines and a strobe register port.
module irq_latch_ctrl
    import irq_latch_pkg::*;
#(
    parameter int unsigned LINES = DEF_LINES,
    parameter int unsigned CNT_W = DEF_CNT_W,
    localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req_lines,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_addr,
    input  logic [LINES-1:0] reg_wdata,
    output logic [LINES-1:0] reg_rdata,
    input  logic [IDX_W-1:0] stat_idx,
    output logic [CNT_W-1:0] stat_count,
    output logic             cpu_irq
);

    logic [LINES-1:0] live_q;
    logic [LINES-1:0] rise;
    reg_sel_e         sel;

    // Map the raw address bit onto the register selector.
    always_comb begin
        sel = reg_sel_e'(reg_addr);
    end

    irq_line_sampler #(.LINES(LINES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_lines (req_lines),
        .live_q    (live_q),
        .rise      (rise)
    );

    irq_pending_core #(.LINES(LINES)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .live    (live_q),
        .wr_en   (reg_wr),
        .rd_en   (reg_rd),
        .sel     (sel),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .irq_out (cpu_irq)
    );

    irq_event_counters #(.LINES(LINES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_counters (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .idx       (stat_idx),
        .count_out (stat_count)
    );

endmodule

// File: tb/irq_latch_ctrl_tb.sv
// Bench for irq_latch_ctrl: directed corner cases plus seeded random
// traffic, compared every cycle against a model built from the requirements.
module irq_latch_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_lines = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  stat_idx = '0;
    logic [31:0] stat_count;
    logic        cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state.
    logic [31:0] m_live = '0, m_prev = '0, m_pend = '0, m_mask = '0, m_rdata = '0;
    logic        m_irq = 1'b0;
    logic [31:0] m_cnt [32];

    always #2.5 clk = ~clk;

    irq_latch_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_lines  (req_lines),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .stat_idx   (stat_idx),
        .stat_count (stat_count),
        .cpu_irq    (cpu_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Next pending value per R2/R4: clear acknowledged bits, then OR live.
    function automatic logic [31:0] next_pend(input logic [31:0] p, input logic [31:0] ack,
                                              input logic [31:0] lv);
        return (p & ~ack) | lv;
    endfunction

    // Advance the model by one edge using the inputs currently driven.
    task automatic model_edge();
        logic [31:0] ack, nmask, npend;
        if (!rst_n) begin
            m_live = '0; m_prev = '0; m_pend = '0; m_mask = '0; m_rdata = '0; m_irq = 1'b0;
            for (int i = 0; i < 32; i++) m_cnt[i] = '0;
            return;
        end
        ack   = (reg_wr && reg_addr) ? reg_wdata : '0;
        nmask = (reg_wr && !reg_addr) ? reg_wdata : m_mask;
        npend = next_pend(m_pend, ack, m_live);
        if (reg_rd) m_rdata = reg_addr ? m_pend : m_mask;
        for (int i = 0; i < 32; i++)
            if (m_live[i] && !m_prev[i]) m_cnt[i] = m_cnt[i] + 1;
        m_prev = m_live;
        m_live = req_lines;
        m_pend = npend;
        m_mask = nmask;
        m_irq  = |(npend & nmask);
    endtask

    // One cycle: inputs are already driven at a negedge; step and compare.
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R3 irq", {31'b0, cpu_irq}, {31'b0, m_irq});
        chk("R8/R7 stat", stat_count, m_cnt[stat_idx]);
        chk("R6 rdata", reg_rdata, m_rdata);
    endtask

    task automatic drive(input logic [31:0] req, input logic wr, input logic rd,
                         input logic addr, input logic [31:0] wd);
        req_lines = req; reg_wr = wr; reg_rd = rd; reg_addr = addr; reg_wdata = wd;
        tick();
    endtask

    // Read a register (0 mask, 1 pending); value is on reg_rdata after the edge.
    task automatic rd_reg(input logic addr, input logic [31:0] req, output logic [31:0] val);
        drive(req, 1'b0, 1'b1, addr, '0);
        val = reg_rdata;
    endtask

    // Watchdog.
    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) m_cnt[i] = '0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            req_lines = 32'hFFFF_FFFF;
            tick();
        end
        rst_n = 1'b1;
        req_lines = '0;
        // R9: quiet after reset, even though lines were high during reset.
        chk("R9 irq after reset", {31'b0, cpu_irq}, 32'd0);
        chk("R9 counter after reset", stat_count, 32'd0);
        rd_reg(1'b0, '0, v); chk("R9 mask after reset", v, 32'd0);
        rd_reg(1'b1, '0, v); chk("R9 pending after reset", v, 32'd0);

        // R5: enable everything; no pending yet, so no request.
        drive('0, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
        chk("R5 irq low with empty pending", {31'b0, cpu_irq}, 32'd0);

        // R1/R2: one-cycle pulse on line 5 latches and stays after release.
        drive(32'h20, 1'b0, 1'b0, 1'b0, '0);
        drive('0, 1'b0, 1'b0, 1'b0, '0);
        chk("R1 pulse reaches irq", {31'b0, cpu_irq}, 32'd1);
        drive('0, 1'b0, 1'b0, 1'b0, '0);
        rd_reg(1'b1, '0, v); chk("R2 sticky bit5", v, 32'h20);

        // R5: mask to zero drops the request at the same edge.
        drive('0, 1'b1, 1'b0, 1'b0, 32'h0);
        chk("R5 mask clear drops irq", {31'b0, cpu_irq}, 32'd0);
        drive('0, 1'b1, 1'b0, 1'b0, 32'h20);
        chk("R5 mask set raises irq", {31'b0, cpu_irq}, 32'd1);

        // R4: acknowledge while line 5 is held high keeps the bit.
        drive(32'h20, 1'b0, 1'b0, 1'b0, '0);
        drive(32'h20, 1'b0, 1'b0, 1'b0, '0);
        drive(32'h20, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF);
        chk("R4 held line survives ack", {31'b0, cpu_irq}, 32'd1);
        rd_reg(1'b1, 32'h20, v); chk("R4 pending after ack", v, 32'h20);
        // Release, let live state drain, then acknowledge clears it.
        drive('0, 1'b0, 1'b0, 1'b0, '0);
        drive('0, 1'b0, 1'b0, 1'b0, '0);
        drive('0, 1'b1, 1'b0, 1'b1, 32'h20);
        chk("R4 ack clears released line", {31'b0, cpu_irq}, 32'd0);
        rd_reg(1'b1, '0, v); chk("R4 pending empty", v, 32'd0);

        // R7: three pulses on line 3, then a long hold counts once more.
        stat_idx = 5'd3;
        for (int k = 0; k < 3; k++) begin
            drive(32'h8, 1'b0, 1'b0, 1'b0, '0);
            drive('0, 1'b0, 1'b0, 1'b0, '0);
        end
        drive('0, 1'b0, 1'b0, 1'b0, '0);
        chk("R7 three pulses", stat_count, 32'd3);
        for (int k = 0; k < 10; k++) drive(32'h8, 1'b0, 1'b0, 1'b0, '0);
        chk("R7 long hold counts once", stat_count, 32'd4);
        // R8: another index shows its own (zero) count.
        stat_idx = 5'd31;
        drive('0, 1'b0, 1'b0, 1'b0, '0);
        chk("R8 index 31 count", stat_count, 32'd0);

        // Random mix of all functions in the same cycles.
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom & $urandom & $urandom;
            stat_idx = 5'($urandom);
            drive(r, ($urandom % 4) == 0, ($urandom % 3) == 0, 1'($urandom),
                  $urandom);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule